// File: doc/BRIEF.md
# Four-Level Address Strap Decoder

This block works out how each of two address-strap pins is wired on the board: tied low, tied high, wired to the serial clock line, or wired to the serial data line. It watches already synchronised samples of both straps next to samples of SCL and SDA, framed by START and STOP strobes from a bus monitor. At every STOP that closes a transmission it re-classifies both straps, whichever device was addressed. From the two 2-bit codes it forms the low four bits of the slave address, so the address can be rewired without a power cycle.

Before any bus traffic has been seen, a strap wired to a bus line cannot be told apart from one tied high, because idle bus lines rest high. On the first clock after reset the decoder therefore classifies each strap by its level alone. From that first classification it fixes, once, a pullup enable for each 4-port group and a power-up default output level for the 8 ports. Strap A governs ports 3..0 and strap B governs ports 7..4. Later re-decodes change only the address nibble.

Top module: `addr_strap_decoder`

## Requirements
- R1: While reset is asserted, the address nibble reads 4'b0101 (both straps coded high), both pullup enables are 1, and the port default pattern is 8'hFF.
- R2: On the first rising edge after reset is released, each strap's code becomes 01 if its sample is 1 and 00 if it is 0. Pullup enable bit i and all four default bits of group i take strap i's level, where strap A is bit 0 and covers ports 3..0, and strap B is bit 1 and covers ports 7..4. All of these are visible after that edge.
- R3: A strap whose sample equalled SCL on every sampled cycle of the transmission, and differed from SDA on at least one, is coded 10.
- R4: A strap whose sample equalled SDA on every sampled cycle, and differed from SCL on at least one, is coded 11.
- R5: Any other strap is coded by its level on the STOP cycle: 01 if high, 00 if low. This includes a transmission in which SCL and SDA never disagreed.
- R6: The address nibble is {strap B code, strap A code}, that is bits 3:2 for B and bits 1:0 for A. It changes only at the edge of a STOP strobe that follows a START. A STOP strobe with no START before it leaves the nibble unchanged.
- R7: A START strobe, including a repeated START, discards the history. The sampled cycles are those after the latest START, up to and including the STOP cycle.
- R8: After the first clock following reset, the pullup enables and the port default pattern never change until the next reset.
- R9: The two straps are classified independently within the same transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_pin_i | input | 2 | Synchronised strap samples; bit 0 is strap A, bit 1 is strap B |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample |
| start_i | input | 1 | One-cycle START (or repeated START) strobe |
| stop_i | input | 1 | One-cycle STOP strobe |
| addr_nibble_o | output | 4 | Low slave-address bits {B code, A code} |
| pullup_en_o | output | 2 | Pullup enable per 4-port group |
| port_default_o | output | 8 | Power-up default level for each port |

## Verification
The hardest situation to bring about is one where only the discarding of history at a repeated START decides the result. In the test, strap A is tied low before the repeated START and follows SDA after it. If the history were kept, the mismatches would push the strap into level coding and give 01; with the history discarded the code is 11. A frame with no data bits, in which SCL never falls, drives the level-coding fallback for straps wired to a bus line. Resets with different strap levels show that the power-up capture uses the level alone.

// File: rtl/addr_strap_pkg.sv
package addr_strap_pkg;

    typedef enum logic [1:0] {
        STRAP_LOW  = 2'b00,
        STRAP_HIGH = 2'b01,
        STRAP_SCL  = 2'b10,
        STRAP_SDA  = 2'b11
    } strap_code_e;

    // Per-strap tracking state: sticky disagreement flags plus the committed code
    typedef struct packed {
        logic        miss_scl;
        logic        miss_sda;
        strap_code_e code;
    } cls_state_t;

    typedef struct packed {
        logic active;
        logic init_done;
    } win_state_t;

    function automatic strap_code_e classify(input logic miss_scl,
                                             input logic miss_sda,
                                             input logic level);
        strap_code_e res;
        if (!miss_scl && miss_sda)      res = STRAP_SCL;
        else if (!miss_sda && miss_scl) res = STRAP_SDA;
        else if (level)                 res = STRAP_HIGH;
        else                            res = STRAP_LOW;
        return res;
    endfunction

endpackage

// File: rtl/strap_bus_window.sv
module strap_bus_window
    import addr_strap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    output logic active_o,
    output logic init_o
);

    win_state_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        w_d.init_done = 1'b1;
        if (start_i)     w_d.active = 1'b1;
        else if (stop_i) w_d.active = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign active_o = w_q.active;
    assign init_o   = !w_q.init_done;

endmodule

// File: rtl/strap_pin_classifier.sv
module strap_pin_classifier
    import addr_strap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_i,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic        init_i,
    input  logic        start_i,
    input  logic        active_i,
    input  logic        stop_i,
    output strap_code_e code_o
);

    cls_state_t s_d, s_q;
    logic       miss_scl_n, miss_sda_n;

    always_comb begin
        s_d        = s_q;
        miss_scl_n = s_q.miss_scl | (pin_i ^ scl_i);
        miss_sda_n = s_q.miss_sda | (pin_i ^ sda_i);
        if (start_i) begin
            s_d.miss_scl = 1'b0;
            s_d.miss_sda = 1'b0;
        end else if (active_i) begin
            s_d.miss_scl = miss_scl_n;
            s_d.miss_sda = miss_sda_n;
            if (stop_i) s_d.code = classify(miss_scl_n, miss_sda_n, pin_i);
        end
        // First cycle after reset: bus lines assumed idle, level only
        if (init_i) s_d.code = pin_i ? STRAP_HIGH : STRAP_LOW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.miss_scl <= 1'b0;
            s_q.miss_sda <= 1'b0;
            s_q.code     <= STRAP_HIGH;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o = s_q.code;

endmodule

// File: rtl/addr_strap_decoder.sv
module addr_strap_decoder
    import addr_strap_pkg::*;
#(
    parameter int NUM_PINS      = 2,
    parameter int PORTS_PER_PIN = 4,
    localparam int NIB_W        = 2 * NUM_PINS,
    localparam int PORT_W       = NUM_PINS * PORTS_PER_PIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PINS-1:0] strap_pin_i,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic [NIB_W-1:0]  addr_nibble_o,
    output logic [NUM_PINS-1:0] pullup_en_o,
    output logic [PORT_W-1:0] port_default_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] pull;
        logic [PORT_W-1:0]   dflt;
    } dflt_state_t;

    logic        bus_active;
    logic        init_cycle;
    dflt_state_t p_d, p_q;

    strap_bus_window u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .stop_i  (stop_i),
        .active_o(bus_active),
        .init_o  (init_cycle)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        strap_code_e code_w;

        strap_pin_classifier u_cls (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (strap_pin_i[g]),
            .scl_i   (scl_i),
            .sda_i   (sda_i),
            .init_i  (init_cycle),
            .start_i (start_i),
            .active_i(bus_active),
            .stop_i  (stop_i),
            .code_o  (code_w)
        );

        assign addr_nibble_o[2*g +: 2] = code_w;
    end

    always_comb begin
        p_d = p_q;
        if (init_cycle) begin
            for (int g = 0; g < NUM_PINS; g++) begin
                p_d.pull[g]                           = strap_pin_i[g];
                p_d.dflt[g*PORTS_PER_PIN +: PORTS_PER_PIN] = {PORTS_PER_PIN{strap_pin_i[g]}};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '1;
        else        p_q <= p_d;
    end

    assign pullup_en_o    = p_q.pull;
    assign port_default_o = p_q.dflt;

endmodule

// File: rtl/addr_strap_decoder_chk.sv
module addr_strap_decoder_chk #(
    parameter int NUM_PINS      = 2,
    parameter int PORTS_PER_PIN = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            stop_i,
    input logic                            active,
    input logic                            init,
    input logic [2*NUM_PINS-1:0]           addr_nibble,
    input logic [NUM_PINS-1:0]             pullup_en,
    input logic [NUM_PINS*PORTS_PER_PIN-1:0] port_default
);

    assert_nibble_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(stop_i && active) && !init) |=> $stable(addr_nibble));

    assert_defaults_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !init |=> $stable(port_default));

    assert_pullups_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !init |=> $stable(pullup_en));

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
        assert_default_uniform_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (port_default[g*PORTS_PER_PIN +: PORTS_PER_PIN] == '0) ||
            (port_default[g*PORTS_PER_PIN +: PORTS_PER_PIN] == '1));

        assert_pullup_tracks_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
            pullup_en[g] == port_default[g*PORTS_PER_PIN]);
    end

endmodule

bind addr_strap_decoder addr_strap_decoder_chk #(
    .NUM_PINS     (NUM_PINS),
    .PORTS_PER_PIN(PORTS_PER_PIN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (stop_i),
    .active      (bus_active),
    .init        (init_cycle),
    .addr_nibble (addr_nibble_o),
    .pullup_en   (pullup_en_o),
    .port_default(port_default_o)
);

// File: tb/addr_strap_decoder_tb.sv
module addr_strap_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap_pin_i = 2'b00;
    logic       scl_i = 1'b1, sda_i = 1'b1, start_i = 1'b0, stop_i = 1'b0;
    logic [3:0] addr_nibble_o;
    logic [1:0] pullup_en_o;
    logic [7:0] port_default_o;

    int checks = 0;
    int failures = 0;
    logic [1:0] cur_ma = 2'd0, cur_mb = 2'd0;  // 0 low, 1 high, 2 follows SCL, 3 follows SDA

    always #5 clk = ~clk;

    addr_strap_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .strap_pin_i(strap_pin_i),
        .scl_i(scl_i), .sda_i(sda_i), .start_i(start_i), .stop_i(stop_i),
        .addr_nibble_o(addr_nibble_o), .pullup_en_o(pullup_en_o),
        .port_default_o(port_default_o)
    );

    // [7:6] mode B, [5:4] mode A, [3:0] expected nibble
    localparam logic [7:0] VEC [16] = '{
        8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77,
        8'h88, 8'h99, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE, 8'hFF
    };

    function automatic logic pinval(input logic [1:0] m, input logic scl, input logic sda);
        case (m)
            2'd0:    return 1'b0;
            2'd1:    return 1'b1;
            2'd2:    return scl;
            default: return sda;
        endcase
    endfunction

    task automatic step(input logic scl, input logic sda, input logic st, input logic sp);
        @(negedge clk);
        scl_i = scl; sda_i = sda; start_i = st; stop_i = sp;
        strap_pin_i = {pinval(cur_mb, scl, sda), pinval(cur_ma, scl, sda)};
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            step(1'b0, b[i], 1'b0, 1'b0);
            step(1'b1, b[i], 1'b0, 1'b0);
        end
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic finish_stop();
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic frame(input logic [1:0] ma, input logic [1:0] mb, input logic [7:0] b);
        cur_ma = ma; cur_mb = mb;
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        send_byte(b);
        finish_stop();
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] ma, input logic [1:0] mb);
        cur_ma = ma; cur_mb = mb;
        @(negedge clk);
        rst_n = 1'b0;
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R1 nibble in reset", {4'h0, addr_nibble_o}, 8'h05);
        check("R1 pullups in reset", {6'h0, pullup_en_o}, 8'h03);
        check("R1 defaults in reset", port_default_o, 8'hFF);
        rst_n = 1'b1;
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R2 nibble after init", {4'h0, addr_nibble_o}, {4'h0, 2'b00, mb[0], 1'b0, ma[0]});
        check("R2 pullups after init", {6'h0, pullup_en_o}, {6'h0, mb[0], ma[0]});
        check("R2 defaults after init", port_default_o, {{4{mb[0]}}, {4{ma[0]}}});
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        do_reset(2'd0, 2'd1);

        // Table: every strap combination, two data patterns (R3 R4 R5 R6 R9)
        for (int i = 0; i < 16; i++) begin
            frame(VEC[i][5:4], VEC[i][7:6], i[0] ? 8'h3C : 8'hA5);
            check("R3/R4/R5 R6 R9 nibble", {4'h0, addr_nibble_o}, {4'h0, VEC[i][3:0]});
        end

        // R8: redecodes leave the power-up capture alone
        check("R8 pullups kept", {6'h0, pullup_en_o}, 8'h02);
        check("R8 defaults kept", port_default_o, 8'hF0);

        // R6: STOP without START ignored
        cur_ma = 2'd0; cur_mb = 2'd0;
        step(1'b1, 1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R6 lone stop", {4'h0, addr_nibble_o}, 8'h0F);

        // R6: START and data without STOP does not commit
        step(1'b1, 1'b0, 1'b1, 1'b0);
        send_byte(8'hA5);
        check("R6 no commit before stop", {4'h0, addr_nibble_o}, 8'h0F);
        finish_stop();
        check("R6 commit at stop", {4'h0, addr_nibble_o}, 8'h00);

        // R7: repeated START discards history (A low then SDA, B high)
        cur_ma = 2'd0; cur_mb = 2'd1;
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        send_byte(8'hA5);
        cur_ma = 2'd3;
        step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        send_byte(8'h5A);
        finish_stop();
        check("R7 restart clears", {4'h0, addr_nibble_o}, 8'h07);

        // R5: frame with no clocking, bus-wired straps fall back to level high
        cur_ma = 2'd2; cur_mb = 2'd3;
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R5 no-clock level", {4'h0, addr_nibble_o}, 8'h05);

        // R2: other power-up levels
        do_reset(2'd1, 2'd1);
        do_reset(2'd0, 2'd0);
        do_reset(2'd1, 2'd0);
        frame(2'd2, 2'd3, 8'hA5);
        check("R9 independent straps", {4'h0, addr_nibble_o}, 8'h0E);
        check("R8 defaults after redecode", port_default_o, 8'h0F);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule